// File: doc/BRIEF.md
# SVGA Register File Access Gate

This block is the processor-facing register file of an SVGA display controller. It sits on an 8-bit I/O bus with a 16-bit port address. It holds the miscellaneous output register and the index/data pairs for the sequencer, the graphics controller and the CRT controller. Each register is exported as a flat vector to the rest of the controller. Standard register meanings are left to the consumers; this block only stores the values and decides which accesses take effect.

Around plain storage it applies the following gates:

- The mono and colour CRTC port ranges are swapped by the I/O-select bit.
- Each group of extension registers has its own unlock key.
- The legacy CRTC write-protect bit guards the low timing registers.
- A range of CRTC indices holds read-only identification bytes, set by a parameter.
- A one-cycle pulse flags any CRTC change that affects display timing.

The chip-variant parameter `ENHANCED` selects the basic part (0) or the enhanced part (1). Reads are registered: `ioRdData` is valid in the cycle after `ioRd`. Writes take effect at the clock edge where `ioWr` is sampled. When a read and a write fall in the same cycle, the read returns the value held before the write.

Top module: `vga_regfile_gate`

## Requirements
- R1: After reset the miscellaneous output register (written at 0x3C2, read at 0x3CC) holds 0x01, and every other register reads 0x00.
- R2: While miscellaneous bit 0 is 0, any port 0x3Bx or 0x3Dx is accessed as port XOR 0x60. With this swap the CRTC index/data pair moves from 0x3D4/0x3D5 to 0x3B4/0x3B5, and 0x3D5 then behaves as an unimplemented port.
- R3: Sequencer indices above 7 exist only when ENHANCED=1, and only while sequencer register 6 holds 0x48. When locked, writes to them are dropped and reads return 0xFF. An index above 0x12 always reads 0xFF.
- R4: Graphics indices 0x9 to 0xE take writes only while graphics register 0xF bits [2:0] equal 5. They read 0xFF while bit 4 of register 0xF is set.
- R5: The CRTC index register (0x3D4) keeps 6 bits when ENHANCED=1 and 5 bits otherwise.
- R6: While CRTC register 0x11 bit 7 is set, writes to CRTC 0 to 6 are dropped, and a write to CRTC 7 changes only its bit 4.
- R7: CRTC indices above 0x29 take writes only while CRTC 0x29 bits [2:0] equal 5. Indices 0x2A to 0x2F read 0xFF unless (CRTC 0x29 AND 0x88) equals 0x80.
- R8: CRTC indices 0x31 to 0x37 are read-only and return the bytes of the ID_BYTES parameter, most significant byte first. Writes to them are dropped.
- R9: A read of port 0x3C2 returns 0x10.
- R10: `timingPulse` is high for one cycle after a CRTC data write that changes the stored value at an index outside 0x0E to 0x10. A write that leaves the value unchanged, or that targets 0x0E to 0x10, gives no pulse.
- R11: A read of any port that has no register returns 0xFF.
- R12: A read and a write of the same register in the same cycle return the old value, and the new value is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioAddr | input | 16 | I/O port address |
| ioWrData | input | 8 | Write data |
| ioWr | input | 1 | Write strobe |
| ioRd | input | 1 | Read strobe |
| ioRdData | output | 8 | Read data, valid the cycle after ioRd |
| miscReg | output | 8 | Miscellaneous output register |
| seqRegs | output | 256 | Sequencer registers, index n in bits [8n+7:8n] |
| gfxRegs | output | 128 | Graphics controller registers |
| crtcRegs | output | 512 | CRTC registers |
| timingPulse | output | 1 | Timing-relevant CRTC change |

## Verification
A register read and a register write can fall in the same cycle on the same data port. The bench provokes this by raising `ioRd` and `ioWr` together on CRTC data after a known value has been stored. The scoreboard expects the pre-write value on `ioRdData`, and a separate read later expects the new value. The same write is chosen to change the value at a timing index, so the cycle after it must also show `timingPulse`. This overlap exercises the read path, the store and the change detector at one clock edge.

// File: rtl/vga_gate_pkg.sv
package vga_gate_pkg;
  localparam int SEQ_IDX_W  = 5;
  localparam int GFX_IDX_W  = 4;
  localparam int CRTC_IDX_W = 6;
  localparam int SEQ_N  = 1 << SEQ_IDX_W;
  localparam int GFX_N  = 1 << GFX_IDX_W;
  localparam int CRTC_N = 1 << CRTC_IDX_W;

  typedef enum logic [3:0] {
    RD_NONE, RD_MISC, RD_FIXED, RD_SEQIDX, RD_SEQ,
    RD_GFXIDX, RD_GFX, RD_CRTCIDX, RD_CRTC, RD_ID
  } rdSel_e;

  typedef struct packed {
    logic   wrMisc;
    logic   wrSeqIdx;
    logic   wrSeqData;
    logic   wrGfxIdx;
    logic   wrGfxData;
    logic   wrCrtcIdx;
    logic   wrCrtcData;
    logic   crtcBit4Only;
    logic   rdEn;
    rdSel_e rdSel;
  } strobe_t;

  typedef struct packed {
    logic                  ioSel;
    logic [SEQ_IDX_W-1:0]  seqIdx;
    logic [7:0]            seqKey;
    logic [GFX_IDX_W-1:0]  gfxIdx;
    logic [7:0]            gfxLock;
    logic [CRTC_IDX_W-1:0] crtcIdx;
    logic                  crtcProtect;
    logic [7:0]            crtcLock;
  } state_t;
endpackage

// File: rtl/vga_gate_ctrl.sv
module vga_gate_ctrl
  import vga_gate_pkg::*;
#(
  parameter bit ENHANCED = 1'b1
) (
  input  logic [15:0] ioAddr,
  input  logic        ioWr,
  input  logic        ioRd,
  input  state_t      st,
  output strobe_t     strb
);
  logic [15:0] effAddr;
  logic        monoOrColour;
  logic        seqExtOk, gfxExtIdx, crtcIdRange;

  always_comb begin
    monoOrColour = (ioAddr[15:4] == 12'h03B) || (ioAddr[15:4] == 12'h03D);
    effAddr      = (!st.ioSel && monoOrColour) ? (ioAddr ^ 16'h0060) : ioAddr;
    seqExtOk     = ENHANCED && (st.seqKey == 8'h48);
    gfxExtIdx    = (st.gfxIdx >= 4'h9) && (st.gfxIdx <= 4'hE);
    crtcIdRange  = (st.crtcIdx >= 6'h31) && (st.crtcIdx <= 6'h37);
  end

  always_comb begin
    strb = '0;
    strb.rdSel = RD_NONE;
    strb.rdEn  = ioRd;
    if (ioWr) begin
      unique case (effAddr)
        16'h03C2: strb.wrMisc   = 1'b1;
        16'h03C4: strb.wrSeqIdx = 1'b1;
        16'h03C5: strb.wrSeqData = (st.seqIdx <= 5'd7) || seqExtOk;
        16'h03CE: strb.wrGfxIdx = 1'b1;
        16'h03CF: strb.wrGfxData = !gfxExtIdx || (st.gfxLock[2:0] == 3'd5);
        16'h03D4: strb.wrCrtcIdx = 1'b1;
        16'h03D5: begin
          strb.wrCrtcData = 1'b1;
          if (st.crtcProtect && st.crtcIdx < 6'd7) strb.wrCrtcData = 1'b0;
          if (st.crtcProtect && st.crtcIdx == 6'd7) strb.crtcBit4Only = 1'b1;
          if (st.crtcIdx > 6'h29 && st.crtcLock[2:0] != 3'd5) strb.wrCrtcData = 1'b0;
          if (crtcIdRange) strb.wrCrtcData = 1'b0;
        end
        default: ;
      endcase
    end
    unique case (effAddr)
      16'h03C2: strb.rdSel = RD_FIXED;
      16'h03CC: strb.rdSel = RD_MISC;
      16'h03C4: strb.rdSel = RD_SEQIDX;
      16'h03C5: strb.rdSel = (st.seqIdx <= 5'd7) ? RD_SEQ :
                             (seqExtOk && st.seqIdx <= 5'h12) ? RD_SEQ : RD_NONE;
      16'h03CE: strb.rdSel = RD_GFXIDX;
      16'h03CF: strb.rdSel = (gfxExtIdx && st.gfxLock[4]) ? RD_NONE : RD_GFX;
      16'h03D4: strb.rdSel = RD_CRTCIDX;
      16'h03D5: begin
        if (crtcIdRange) strb.rdSel = RD_ID;
        else if (st.crtcIdx >= 6'h2A && st.crtcIdx <= 6'h2F &&
                 (st.crtcLock & 8'h88) != 8'h80) strb.rdSel = RD_NONE;
        else strb.rdSel = RD_CRTC;
      end
      default: strb.rdSel = RD_NONE;
    endcase
  end
endmodule

// File: rtl/vga_gate_dp.sv
module vga_gate_dp
  import vga_gate_pkg::*;
#(
  parameter bit          ENHANCED = 1'b1,
  parameter logic [55:0] ID_BYTES = 56'h0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               strb,
  input  logic [7:0]            wrData,
  output state_t                st,
  output logic [7:0]            rdData,
  output logic [7:0]            miscReg,
  output logic [SEQ_N*8-1:0]    seqRegs,
  output logic [GFX_N*8-1:0]    gfxRegs,
  output logic [CRTC_N*8-1:0]   crtcRegs,
  output logic                  timingPulse
);
  localparam int ID_FIRST = 'h31;

  logic [SEQ_N-1:0][7:0]  seqMem;
  logic [GFX_N-1:0][7:0]  gfxMem;
  logic [CRTC_N-1:0][7:0] crtcMem;
  logic [SEQ_IDX_W-1:0]   seqIdx;
  logic [GFX_IDX_W-1:0]   gfxIdx;
  logic [CRTC_IDX_W-1:0]  crtcIdx;
  logic [7:0]             crtcOld, crtcNew, idByte, rdNext;
  logic                   timingIdx;

  always_comb begin
    crtcOld   = crtcMem[crtcIdx];
    crtcNew   = strb.crtcBit4Only ? {crtcOld[7:5], wrData[4], crtcOld[3:0]} : wrData;
    timingIdx = (crtcIdx < 6'h0E) || (crtcIdx > 6'h10);
    idByte    = ID_BYTES[8*(6-(int'(crtcIdx)-ID_FIRST)) +: 8];
    unique case (strb.rdSel)
      RD_MISC:    rdNext = miscReg;
      RD_FIXED:   rdNext = 8'h10;
      RD_SEQIDX:  rdNext = {{(8-SEQ_IDX_W){1'b0}}, seqIdx};
      RD_SEQ:     rdNext = seqMem[seqIdx];
      RD_GFXIDX:  rdNext = {{(8-GFX_IDX_W){1'b0}}, gfxIdx};
      RD_GFX:     rdNext = gfxMem[gfxIdx];
      RD_CRTCIDX: rdNext = {{(8-CRTC_IDX_W){1'b0}}, crtcIdx};
      RD_CRTC:    rdNext = crtcOld;
      RD_ID:      rdNext = idByte;
      default:    rdNext = 8'hFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      miscReg     <= 8'h01;
      seqMem      <= '0;
      gfxMem      <= '0;
      crtcMem     <= '0;
      seqIdx      <= '0;
      gfxIdx      <= '0;
      crtcIdx     <= '0;
      rdData      <= '0;
      timingPulse <= 1'b0;
    end else begin
      timingPulse <= 1'b0;
      if (strb.rdEn)      rdData <= rdNext;
      if (strb.wrMisc)    miscReg <= wrData;
      if (strb.wrSeqIdx)  seqIdx <= wrData[SEQ_IDX_W-1:0];
      if (strb.wrSeqData) seqMem[seqIdx] <= wrData;
      if (strb.wrGfxIdx)  gfxIdx <= wrData[GFX_IDX_W-1:0];
      if (strb.wrGfxData) gfxMem[gfxIdx] <= wrData;
      if (strb.wrCrtcIdx)
        crtcIdx <= ENHANCED ? wrData[5:0] : {1'b0, wrData[4:0]};
      if (strb.wrCrtcData) begin
        crtcMem[crtcIdx] <= crtcNew;
        timingPulse      <= (crtcNew != crtcOld) && timingIdx;
      end
    end
  end

  always_comb begin
    st.ioSel       = miscReg[0];
    st.seqIdx      = seqIdx;
    st.seqKey      = seqMem[6];
    st.gfxIdx      = gfxIdx;
    st.gfxLock     = gfxMem[GFX_N-1];
    st.crtcIdx     = crtcIdx;
    st.crtcProtect = crtcMem['h11][7];
    st.crtcLock    = crtcMem['h29];
  end

  assign seqRegs  = seqMem;
  assign gfxRegs  = gfxMem;
  assign crtcRegs = crtcMem;

  assert_seq_locked_R3: assert property (@(posedge clk) disable iff (!rstN)
    (seqMem[6] != 8'h48) |=> $stable(seqMem[SEQ_N-1:8]));
  assert_gfx_locked_R4: assert property (@(posedge clk) disable iff (!rstN)
    (gfxMem[GFX_N-1][2:0] != 3'd5) |=> $stable(gfxMem[14:9]));
  assert_crtc_low_protect_R6: assert property (@(posedge clk) disable iff (!rstN)
    crtcMem['h11][7] |=> $stable(crtcMem[6:0]));
  assert_crtc7_bits_R6: assert property (@(posedge clk) disable iff (!rstN)
    crtcMem['h11][7] |=> ($stable(crtcMem[7][7:5]) && $stable(crtcMem[7][3:0])));
endmodule

// File: rtl/vga_regfile_gate.sv
module vga_regfile_gate
  import vga_gate_pkg::*;
#(
  parameter bit          ENHANCED = 1'b1,
  parameter logic [55:0] ID_BYTES = 56'h53_56_47_41_58_32_31
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [15:0]         ioAddr,
  input  logic [7:0]          ioWrData,
  input  logic                ioWr,
  input  logic                ioRd,
  output logic [7:0]          ioRdData,
  output logic [7:0]          miscReg,
  output logic [SEQ_N*8-1:0]  seqRegs,
  output logic [GFX_N*8-1:0]  gfxRegs,
  output logic [CRTC_N*8-1:0] crtcRegs,
  output logic                timingPulse
);
  strobe_t strb;
  state_t  st;

  vga_gate_ctrl #(.ENHANCED(ENHANCED)) i_ctrl (
    .ioAddr(ioAddr), .ioWr(ioWr), .ioRd(ioRd), .st(st), .strb(strb)
  );

  vga_gate_dp #(.ENHANCED(ENHANCED), .ID_BYTES(ID_BYTES)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(ioWrData), .st(st),
    .rdData(ioRdData), .miscReg(miscReg), .seqRegs(seqRegs),
    .gfxRegs(gfxRegs), .crtcRegs(crtcRegs), .timingPulse(timingPulse)
  );

  assert_pulse_after_write_R10: assert property (@(posedge clk) disable iff (!rstN)
    timingPulse |-> $past(ioWr));
  assert_fixed_port_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ioRd && ioAddr == 16'h03C2) |=> (ioRdData == 8'h10));
endmodule

// File: tb/test_vga_regfile_gate.sv
module test_vga_regfile_gate;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [15:0]  ioAddr = '0;
  logic [7:0]   ioWrData = '0;
  logic         ioWr = 1'b0;
  logic         ioRd = 1'b0;
  logic [7:0]   ioRdData, miscReg;
  logic [255:0] seqRegs;
  logic [127:0] gfxRegs;
  logic [511:0] crtcRegs;
  logic         timingPulse;

  int checks = 0;
  int errors = 0;
  logic [7:0] expQ[$];
  string      tagQ[$];
  logic       rdSeen = 1'b0;
  logic       lastPulse;
  bit         done = 1'b0;
  logic [55:0] idStr = "SVGAX21";

  always #2 clk = ~clk;

  vga_regfile_gate i_vga_regfile_gate (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWrData(ioWrData),
    .ioWr(ioWr), .ioRd(ioRd), .ioRdData(ioRdData), .miscReg(miscReg),
    .seqRegs(seqRegs), .gfxRegs(gfxRegs), .crtcRegs(crtcRegs),
    .timingPulse(timingPulse)
  );

  always @(posedge clk) rdSeen <= ioRd;

  always @(negedge clk) begin
    if (rdSeen) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL scoreboard empty: actual %02h expected none", ioRdData);
      end else begin
        logic [7:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if (ioRdData !== e) begin
          errors++;
          $display("FAIL %s: actual %02h expected %02h", t, ioRdData, e);
        end
      end
    end
  end

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    ioAddr = a; ioWrData = d; ioWr = 1'b1;
    @(negedge clk);
    ioWr = 1'b0;
    lastPulse = timingPulse;
  endtask

  task automatic rd(input logic [15:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    ioAddr = a; ioRd = 1'b1;
    expQ.push_back(e); tagQ.push_back(t);
    @(negedge clk);
    ioRd = 1'b0;
  endtask

  task automatic rdwr(input logic [15:0] a, input logic [7:0] d,
                      input logic [7:0] e, input string t);
    @(negedge clk);
    ioAddr = a; ioWrData = d; ioRd = 1'b1; ioWr = 1'b1;
    expQ.push_back(e); tagQ.push_back(t);
    @(negedge clk);
    ioRd = 1'b0; ioWr = 1'b0;
    lastPulse = timingPulse;
  endtask

  task automatic chk(input logic act, input logic exp, input string t);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", t, act, exp);
    end
  endtask

  task automatic crtcW(input logic [7:0] i, input logic [7:0] d);
    wr(16'h03D4, i);
    wr(16'h03D5, d);
  endtask

  task automatic crtcR(input logic [7:0] i, input logic [7:0] e, input string t);
    wr(16'h03D4, i);
    rd(16'h03D5, e, t);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset values
    rd(16'h03CC, 8'h01, "R1 misc reset");
    crtcR(8'h01, 8'h00, "R1 crtc reset");
    rd(16'h03C5, 8'h00, "R1 seq reset");
    // R9 / R11
    rd(16'h03C2, 8'h10, "R9 fixed port");
    rd(16'h0300, 8'hFF, "R11 unimplemented port");
    rd(16'h03B5, 8'hFF, "R11 mono data unaliased");
    // R10 timing pulse
    crtcW(8'h01, 8'h5F); chk(lastPulse, 1'b1, "R10 change pulses");
    crtcW(8'h01, 8'h5F); chk(lastPulse, 1'b0, "R10 same value no pulse");
    crtcW(8'h0E, 8'h12); chk(lastPulse, 1'b0, "R10 cursor index no pulse");
    crtcW(8'h12, 8'h34); chk(lastPulse, 1'b1, "R10 high index pulses");
    // R12 read and write in one cycle
    wr(16'h03D4, 8'h01);
    rdwr(16'h03D5, 8'hA0, 8'h5F, "R12 old value on overlap");
    chk(lastPulse, 1'b1, "R12 overlap pulse");
    rd(16'h03D5, 8'hA0, "R12 new value stored");
    // R5 index width
    wr(16'h03D4, 8'hFF);
    rd(16'h03D4, 8'h3F, "R5 index six bits");
    // R7 extended CRTC gate
    crtcW(8'h29, 8'h80);
    crtcW(8'h2A, 8'h77);
    crtcR(8'h2A, 8'h00, "R7 locked write dropped");
    crtcW(8'h29, 8'h85);
    crtcW(8'h2A, 8'h77);
    crtcR(8'h2A, 8'h77, "R7 unlocked write");
    crtcW(8'h29, 8'h05);
    crtcR(8'h2A, 8'hFF, "R7 read hidden");
    // R8 ID bytes
    for (int k = 0; k < 7; k++)
      crtcR(8'h31 + 8'(k), idStr[8*(6-k) +: 8], "R8 id byte");
    crtcW(8'h31, 8'h00);
    crtcR(8'h31, idStr[55:48], "R8 id write dropped");
    // R3 sequencer extension key
    wr(16'h03C4, 8'h02); wr(16'h03C5, 8'h0F);
    rd(16'h03C5, 8'h0F, "R3 low index plain");
    wr(16'h03C4, 8'h10); wr(16'h03C5, 8'h5A);
    rd(16'h03C5, 8'hFF, "R3 locked read");
    wr(16'h03C4, 8'h06); wr(16'h03C5, 8'h48);
    wr(16'h03C4, 8'h10);
    rd(16'h03C5, 8'h00, "R3 locked write dropped");
    wr(16'h03C5, 8'h5A);
    rd(16'h03C5, 8'h5A, "R3 unlocked");
    wr(16'h03C4, 8'h13);
    rd(16'h03C5, 8'hFF, "R3 above 0x12");
    // R4 graphics extension gate
    wr(16'h03CE, 8'h09); wr(16'h03CF, 8'h33);
    rd(16'h03CF, 8'h00, "R4 locked write dropped");
    wr(16'h03CE, 8'h0F); wr(16'h03CF, 8'h05);
    wr(16'h03CE, 8'h09); wr(16'h03CF, 8'h33);
    rd(16'h03CF, 8'h33, "R4 unlocked write");
    wr(16'h03CE, 8'h0F); wr(16'h03CF, 8'h15);
    wr(16'h03CE, 8'h09);
    rd(16'h03CF, 8'hFF, "R4 read hidden");
    // R6 write protect
    crtcW(8'h03, 8'h44);
    crtcW(8'h07, 8'h00);
    crtcW(8'h11, 8'h80);
    crtcW(8'h03, 8'h99);
    crtcR(8'h03, 8'h44, "R6 low register protected");
    crtcW(8'h07, 8'hFF);
    crtcR(8'h07, 8'h10, "R6 only bit 4 of reg 7");
    // R2 port aliasing
    wr(16'h03C2, 8'h00);
    rd(16'h03CC, 8'h00, "R2 misc cleared");
    wr(16'h03B4, 8'h03);
    rd(16'h03B5, 8'h44, "R2 mono data reaches crtc");
    rd(16'h03B4, 8'h03, "R2 mono index");
    rd(16'h03D5, 8'hFF, "R2 colour data moved away");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule